// File: doc/BRIEF.md
# Banked SIMD Vector ALU

This block is the datapath of a small vector coprocessor. It keeps four register banks, called A, B, C and D. Each bank holds eight 32-bit entries. A host fills banks through a per-entry write port and reads any entry back through a matching read port that shows the selected entry combinationally.

A single command starts an element-wise operation. The command carries an opcode, a signed/unsigned flag and an active-lane count. Entry *i* of bank A and entry *i* of bank B are the operands, and entry *i* of bank C receives the result. Only the first *n* entries are written; the rest of bank C is left untouched. Bank D is host storage only.

Add, subtract, multiply and the six bitwise operations finish in one cycle. Divide runs as a bit-serial loop on every lane in parallel, with a busy flag while it runs and a one-cycle completion pulse at the end. Two sticky flags record problems: one for a zero divisor in an active lane, and one for a command that arrived while the block was busy.

Top module: `simd_bank_alu`

## Requirements
- R1: A host write with `host_we_i` high stores `host_wdata_i` at bank `host_bank_i` (0=A, 1=B, 2=C, 3=D), entry `host_idx_i`, at the next clock edge. `host_rdata_o` shows the addressed entry combinationally.
- R2: Opcodes 0 (add), 1 (subtract) and 2 (multiply) produce A op B, keeping the low 32 bits. A command accepted at one clock edge updates bank C at that same edge. `done_o` is high for exactly the following cycle, and `busy_o` stays low.
- R3: Opcodes 5 AND, 6 OR, 7 XOR, 8 NAND and 9 NOR combine A with B bitwise. Opcode 4 writes the bitwise inverse of A, and the contents of B have no effect on it.
- R4: `op_lanes_i` holds the lane count minus one. Entries 0 to `op_lanes_i` of bank C are written, and all higher entries keep their previous value.
- R5: Opcode 3 divides A by B. With `op_signed_i` low the quotient is unsigned. With it high, both operands are two's complement and the quotient is truncated toward zero. The 0x80000000 by -1 case yields 0x80000000. For all other opcodes `op_signed_i` makes no difference.
- R6: After a divide is accepted, `busy_o` is high for exactly 32 cycles. Bank C is updated at the edge where `busy_o` falls, and `done_o` is high for the one cycle after that.
- R7: A divide lane with a zero divisor writes 0xFFFFFFFF to its entry, and the other lanes get normal quotients. If any active lane has a zero divisor, `div_zero_o` becomes high and stays high until reset. Inactive lanes never set it.
- R8: A command presented while `busy_o` is high is ignored: the divide in progress and bank C are unaffected. `cmd_ovf_o` becomes high and stays high until reset.
- R9: Opcodes 10 to 15 change nothing and raise no `done_o`.
- R10: After reset, every entry of every bank reads zero, and `busy_o`, `done_o`, `div_zero_o` and `cmd_ovf_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host entry write enable |
| host_bank_i | input | 2 | Host bank select, 0=A 1=B 2=C 3=D |
| host_idx_i | input | 3 | Host entry index |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Addressed entry, combinational |
| op_valid_i | input | 1 | Command strobe |
| op_code_i | input | 4 | Operation code |
| op_signed_i | input | 1 | Signed interpretation for divide |
| op_lanes_i | input | 3 | Active lane count minus one |
| busy_o | output | 1 | Divide in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Sticky zero-divisor flag |
| cmd_ovf_o | output | 1 | Sticky command-while-busy flag |

## Verification
Most wrong internal state shows up as a bad bank C entry, and it can be seen through the read port in the first idle cycle after the command. A wrong lane mask appears as a modified entry above the lane count, or as a stale one below it. A divider that loses its count or its remainder shows up in two ways: the length of the `busy_o` window differs from 32 cycles, or the quotients are wrong, and both are visible when the divide ends. Flag errors appear on the sticky outputs one cycle after the triggering command, and they persist after that, so a check at any later point still catches them.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_DIV  = 4'd3,
    OP_NOT  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_NAND = 4'd8,
    OP_NOR  = 4'd9
  } op_e;

  localparam int unsigned NUM_BANKS = 4;
  localparam int unsigned BANK_A    = 0;
  localparam int unsigned BANK_B    = 1;
  localparam int unsigned BANK_C    = 2;
endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  logic [2*DATA_W-1:0] prod;

  assign prod = a_i * b_i;

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_MUL:  res_o = prod[DATA_W-1:0];
      OP_NOT:  res_o = ~a_i;
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_NAND: res_o = ~(a_i & b_i);
      OP_NOR:  res_o = ~(a_i | b_i);
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_div_lane.sv
module simd_div_lane #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_i,
  input  logic              signed_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] dvd_q, dvs_q, rem_q;
  logic              neg_q, zero_q;
  logic [DATA_W:0]   rem_sh;
  logic              ge;
  logic [DATA_W-1:0] rem_n, quo_n;
  logic [DATA_W-1:0] a_mag, b_mag;

  assign a_mag  = (signed_i && a_i[DATA_W-1]) ? -a_i : a_i;
  assign b_mag  = (signed_i && b_i[DATA_W-1]) ? -b_i : b_i;
  assign rem_sh = {rem_q, dvd_q[DATA_W-1]};
  assign ge     = rem_sh >= {1'b0, dvs_q};
  assign rem_n  = ge ? DATA_W'(rem_sh - {1'b0, dvs_q}) : rem_sh[DATA_W-1:0];
  assign quo_n  = {dvd_q[DATA_W-2:0], ge};
  // result reflects the step taken at the current edge
  assign res_o  = zero_q ? '1 : (neg_q ? -quo_n : quo_n);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q  <= '0;
      dvs_q  <= '0;
      rem_q  <= '0;
      neg_q  <= 1'b0;
      zero_q <= 1'b1;
    end else if (start_i) begin
      dvd_q  <= a_mag;
      dvs_q  <= b_mag;
      rem_q  <= '0;
      neg_q  <= signed_i && (a_i[DATA_W-1] ^ b_i[DATA_W-1]);
      zero_q <= (b_i == '0);
    end else if (step_i) begin
      dvd_q <= quo_n;
      rem_q <= rem_n;
    end
  end

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !zero_q |-> (rem_q < dvs_q)); // R5
endmodule

// File: rtl/simd_bank_alu.sv
module simd_bank_alu
  import simd_pkg::*;
#(
  parameter int unsigned LANES  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     host_we_i,
  input  logic [1:0]               host_bank_i,
  input  logic [$clog2(LANES)-1:0] host_idx_i,
  input  logic [DATA_W-1:0]        host_wdata_i,
  output logic [DATA_W-1:0]        host_rdata_o,
  input  logic                     op_valid_i,
  input  logic [3:0]               op_code_i,
  input  logic                     op_signed_i,
  input  logic [$clog2(LANES)-1:0] op_lanes_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     div_zero_o,
  output logic                     cmd_ovf_o
);
  localparam int unsigned IDX_W = $clog2(LANES);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] bank_q [NUM_BANKS][LANES];
  logic [DATA_W-1:0] alu_res [LANES];
  logic [DATA_W-1:0] div_res [LANES];
  logic [LANES-1:0]  mask_now, mask_q, zero_b;
  logic              busy_q, done_q, dz_q, ovf_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              known, accept, alu_go, div_go, div_last;

  assign known    = op_code_i <= 4'(OP_NOR);
  assign accept   = op_valid_i && !busy_q && known;
  assign alu_go   = accept && (op_code_i != 4'(OP_DIV));
  assign div_go   = accept && (op_code_i == 4'(OP_DIV));
  assign div_last = busy_q && (cnt_q == CNT_W'(1));

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      mask_now[i] = IDX_W'(i) <= op_lanes_i;
      zero_b[i]   = bank_q[BANK_B][i] == '0;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    simd_lane_alu #(.DATA_W(DATA_W)) u_alu (
      .op_i (op_code_i),
      .a_i  (bank_q[BANK_A][g]),
      .b_i  (bank_q[BANK_B][g]),
      .res_o(alu_res[g])
    );
    simd_div_lane #(.DATA_W(DATA_W)) u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (div_go),
      .step_i  (busy_q),
      .signed_i(op_signed_i),
      .a_i     (bank_q[BANK_A][g]),
      .b_i     (bank_q[BANK_B][g]),
      .res_o   (div_res[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NUM_BANKS; b++)
        for (int i = 0; i < LANES; i++) bank_q[b][i] <= '0;
    end else begin
      if (host_we_i) bank_q[host_bank_i][host_idx_i] <= host_wdata_i;
      // op results take priority over a host write to the same entry
      for (int i = 0; i < LANES; i++) begin
        if (alu_go && mask_now[i]) bank_q[BANK_C][i] <= alu_res[i];
        if (div_last && mask_q[i]) bank_q[BANK_C][i] <= div_res[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dz_q   <= 1'b0;
      ovf_q  <= 1'b0;
      cnt_q  <= '0;
      mask_q <= '0;
    end else begin
      done_q <= alu_go || div_last;
      if (op_valid_i && busy_q) ovf_q <= 1'b1;
      if (div_go) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(DATA_W);
        mask_q <= mask_now;
        if (|(mask_now & zero_b)) dz_q <= 1'b1;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
        if (div_last) busy_q <= 1'b0;
      end
    end
  end

  assign host_rdata_o = bank_q[host_bank_i][host_idx_i];
  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign div_zero_o   = dz_q;
  assign cmd_ovf_o    = ovf_q;

  AST_DONE_AT_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R6
  AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o); // R6
  AST_ALU_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !busy_o && op_code_i <= 4'd9 && op_code_i != 4'd3) |=> (done_o && !busy_o)); // R2
  AST_UNKNOWN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !busy_o && op_code_i > 4'd9) |=> !done_o); // R9
  AST_TOP_LANE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !busy_o && op_lanes_i != IDX_W'(LANES - 1) && op_code_i != 4'd3
     && !(host_we_i && host_bank_i == 2'd2)) |=> $stable(bank_q[BANK_C][LANES-1])); // R4
  AST_OVF_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && busy_o) |=> cmd_ovf_o); // R8
  AST_OVF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ovf_o |=> cmd_ovf_o); // R8
  AST_DZ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_zero_o |=> div_zero_o); // R7
endmodule

// File: tb/test_simd_bank_alu.sv
module test_simd_bank_alu;
  localparam int LANES = 8;
  localparam int W     = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          host_we_i;
  logic [1:0]    host_bank_i;
  logic [2:0]    host_idx_i;
  logic [W-1:0]  host_wdata_i;
  logic [W-1:0]  host_rdata_o;
  logic          op_valid_i;
  logic [3:0]    op_code_i;
  logic          op_signed_i;
  logic [2:0]    op_lanes_i;
  logic          busy_o, done_o, div_zero_o, cmd_ovf_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [W-1:0] ma [LANES];
  logic [W-1:0] mb [LANES];
  logic [W-1:0] mc [LANES];
  bit dz_exp = 1'b0;

  always #2 clk_i = ~clk_i;

  simd_bank_alu i_simd_bank_alu (
    .clk_i, .rst_ni, .host_we_i, .host_bank_i, .host_idx_i, .host_wdata_i,
    .host_rdata_o, .op_valid_i, .op_code_i, .op_signed_i, .op_lanes_i,
    .busy_o, .done_o, .div_zero_o, .cmd_ovf_o
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int bank, input int idx, input logic [W-1:0] d);
    @(negedge clk_i);
    host_we_i = 1'b1; host_bank_i = 2'(bank); host_idx_i = 3'(idx); host_wdata_i = d;
    @(negedge clk_i);
    host_we_i = 1'b0;
  endtask

  task automatic rd(input int bank, input int idx, output logic [W-1:0] d);
    host_bank_i = 2'(bank); host_idx_i = 3'(idx);
    #0.5;
    d = host_rdata_o;
  endtask

  function automatic logic [W-1:0] expect_val(input int op, input bit sg, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] ua, ub, q;
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a * b;
      3: begin
        if (b == 0) return '1;
        if (!sg) return a / b;
        ua = a[W-1] ? -a : a;
        ub = b[W-1] ? -b : b;
        q = ua / ub;
        return (a[W-1] ^ b[W-1]) ? -q : q;
      end
      4: return ~a;
      5: return a & b;
      6: return a | b;
      7: return a ^ b;
      8: return ~(a & b);
      9: return ~(a | b);
      default: return '0;
    endcase
  endfunction

  task automatic check_c(input string req);
    logic [W-1:0] d;
    for (int i = 0; i < LANES; i++) begin
      rd(2, i, d);
      chk(d === mc[i], req, d, mc[i]);
    end
  endtask

  task automatic load_set(input int s);
    logic [W-1:0] a, b;
    for (int i = 0; i < LANES; i++) begin
      case (s)
        0: begin a = (i + 1) * 1000 + 17; b = i + 3; end
        1: begin
          a = 32'h9E37_79B9 * (i + 12);
          b = (i % 2) ? -(i + 2) : (i * 13 + 5);
          if (i == 2) b = 0;
        end
        default: begin
          a = 32'h85EB_CA6B * (i + 23) ^ 32'h8000_0000;
          b = (32'hC2B2_AE35 * (i + 23)) >> (i * 3) | 32'h1;
          if (i == 0) begin a = 32'h8000_0000; b = 32'hFFFF_FFFF; end
        end
      endcase
      ma[i] = a; mb[i] = b;
      wr(0, i, a);
      wr(1, i, b);
    end
  endtask

  task automatic run_op(input int op, input bit sg, input int lc);
    int n;
    string req;
    @(negedge clk_i);
    op_valid_i = 1'b1; op_code_i = 4'(op); op_signed_i = sg; op_lanes_i = 3'(lc);
    @(negedge clk_i);
    op_valid_i = 1'b0;
    if (op == 3) begin
      for (int i = 0; i <= lc; i++) if (mb[i] == 0) dz_exp = 1'b1;
      n = 0;
      while (busy_o && n < 100) begin n++; @(negedge clk_i); end
      chk(n == W, "R6 busy length", n, W);
      chk(done_o === 1'b1, "R6 done after divide", done_o, 1);
      @(negedge clk_i);
      chk(done_o === 1'b0, "R6 done one cycle", done_o, 0);
      chk(div_zero_o === dz_exp, "R7 div_zero flag", div_zero_o, dz_exp);
    end else if (op <= 9) begin
      chk(done_o === 1'b1 && busy_o === 1'b0, "R2 single-cycle done", {done_o, busy_o}, 2'b10);
      @(negedge clk_i);
      chk(done_o === 1'b0, "R2 done one cycle", done_o, 0);
    end else begin
      chk(done_o === 1'b0, "R9 no done for unknown opcode", done_o, 0);
    end
    if (op <= 9)
      for (int i = 0; i <= lc; i++) mc[i] = expect_val(op, sg, ma[i], mb[i]);
    chk(cmd_ovf_o === 1'b0, "R8 no overflow when idle", cmd_ovf_o, 0);
    if (op == 3) req = sg ? "R5 signed divide R7" : "R5 unsigned divide R7";
    else if (op == 4) req = "R3 NOT ignores B R4";
    else if (op >= 5 && op <= 9) req = "R3 logic op R4";
    else if (op > 9) req = "R9 unknown opcode leaves C";
    else req = "R2 arith op R4";
    check_c(req);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    rst_ni = 1'b0; host_we_i = 1'b0; host_bank_i = '0; host_idx_i = '0; host_wdata_i = '0;
    op_valid_i = 1'b0; op_code_i = '0; op_signed_i = 1'b0; op_lanes_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    chk({busy_o, done_o, div_zero_o, cmd_ovf_o} === 4'b0, "R10 flags after reset", {busy_o, done_o, div_zero_o, cmd_ovf_o}, 0);
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < LANES; i++) begin
        rd(b, i, d);
        chk(d === '0, "R10 bank zero after reset", d, 0);
      end
    // R1 write and read every entry of every bank
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < LANES; i++) wr(b, i, (32'h0101_0101 * (b * 8 + i + 1)) ^ 32'hA500_0000);
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < LANES; i++) begin
        rd(b, i, d);
        chk(d === ((32'h0101_0101 * (b * 8 + i + 1)) ^ 32'hA500_0000), "R1 host readback", d,
            (32'h0101_0101 * (b * 8 + i + 1)) ^ 32'hA500_0000);
      end
    for (int i = 0; i < LANES; i++) mc[i] = (32'h0101_0101 * (16 + i + 1)) ^ 32'hA500_0000;

    // sweep: data sets x opcodes x sign x lane counts (R2 R3 R4 R5 R7 R9)
    for (int s = 0; s < 3; s++) begin
      load_set(s);
      for (int lsel = 0; lsel < 3; lsel++)
        for (int op = 0; op < 16; op++)
          for (int sg = 0; sg < 2; sg++)
            run_op(op, sg[0], (lsel == 0) ? 0 : (lsel == 1) ? 3 : 7);
    end

    // R8 command while busy is ignored
    @(negedge clk_i);
    op_valid_i = 1'b1; op_code_i = 4'd3; op_signed_i = 1'b1; op_lanes_i = 3'd7;
    @(negedge clk_i);
    op_code_i = 4'd0; op_signed_i = 1'b0; op_lanes_i = 3'd7;
    @(negedge clk_i);
    op_valid_i = 1'b0;
    chk(cmd_ovf_o === 1'b1, "R8 overflow flag set", cmd_ovf_o, 1);
    chk(busy_o === 1'b1, "R8 divide still running", busy_o, 1);
    while (busy_o) @(negedge clk_i);
    @(negedge clk_i);
    for (int i = 0; i < LANES; i++) mc[i] = expect_val(3, 1'b1, ma[i], mb[i]);
    check_c("R8 ignored command left divide result");
    chk(cmd_ovf_o === 1'b1, "R8 overflow flag sticky", cmd_ovf_o, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule